// File: doc/BRIEF.md
# ADC Channel and Mode Control

This block is the digital controller that sits beside a multiplexed sigma-delta converter. It holds two small configuration registers and a result register, all behind a plain write/read strobe bus. From the configuration it drives the input multiplexer selection, the choice of reference, the power-down and oscillator enables, and an active-low ready flag.

The multiplexer can run in a narrow configuration (eight single inputs measured against a common pin, or four differential pairs) or a wide one (ten single inputs, or five pairs). In the wide configuration only the first reference exists, so the reference-select bit is overridden. The filter reports each finished conversion with a one-cycle pulse. After reset, and after every change of channel or configuration, the controller discards a set number of conversions so that the modulator and filter can settle. Only later results reach the result register and pull the ready flag low.

An active-low reset returns everything to its defaults asynchronously. The default state is power-down, and registers keep their contents while powered down.

Top module: `adc_chan_ctrl`

## Requirements
- R1: With rst_n low, and on the first cycle after it rises: pwr_dn=1, osc_en=0, rdy_n=1, chan_err=0, ref2_sel=0, mux_pos=0, mux_diff=0, and all three registers read back as zero.
- R2: Channel codes 0..N-1 select single input N (mux_diff=0, mux_pos=code). Codes N..N+N/2-1 select pair code-N (mux_diff=1). N is 8 when the wide bit is 0 and 10 when it is 1, so the legal codes are 0..11 or 0..14.
- R3: A write to the control register (address 1, code in bits [3:0], higher bits ignored) with an illegal code sets chan_err and keeps the previous code. A legal write clears chan_err.
- R4: Mode register (address 0) bit 4 selects reference 2 (ref2_sel=1) only while bit 3 (wide) is 0. With wide=1, ref2_sel is 0.
- R5: The mode field is bits [2:0], and 000 means power-down (pwr_dn=1). osc_en = !pwr_dn OR mode bit 5 (oscillator keep-alive).
- R6: A mode write with field 000 forces rdy_n high. While powered down, conversion pulses are ignored, and all registers, including the result register at address 2, keep their values and remain readable. rdata is zero when rd_en is low.
- R7: After reset, after a legal control write that changes the code, or after a mode write that flips the wide bit, the next 3 conversion pulses taken while running are discarded.
- R8: An accepted conversion loads conv_data into the result register, and rdy_n is low from the next cycle. A read of address 2 sets rdy_n high on the following cycle.
- R9: If a conversion is accepted while rdy_n is already low, rdy_n is high for exactly one cycle and then low again, with the new result loaded.
- R10: A mode write that clears the wide bit while the current code is 12 or higher forces the code to 0 and sets chan_err.
- R11: While rst_n is low, writes have no effect. A reset in mid-run restores the R1 state and restarts settling.
- R12: A change of channel or configuration (R7) forces rdy_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 mode, 1 channel, 2 result |
| wdata | input | 8 | Write data |
| rdata | output | RES_W (16) | Read data, combinational, zero when idle |
| conv_done | input | 1 | One-cycle pulse per finished conversion |
| conv_data | input | RES_W (16) | Conversion word valid with conv_done |
| mux_pos | output | SEL_W (4) | Single input index or pair index |
| mux_diff | output | 1 | 1 when a differential pair is selected |
| ref2_sel | output | 1 | 1 selects the second reference |
| pwr_dn | output | 1 | Converter power-down enable |
| osc_en | output | 1 | Oscillator enable |
| rdy_n | output | 1 | Active-low result-ready flag |
| chan_err | output | 1 | Last channel request was refused |

## Verification
The bench goes after the settling count: a controller that is off by one would publish the third discarded conversion or hide the fourth. It then stacks conversions without a read, so a ready flag that never blinks, or blinks for two cycles, is caught on the exact cycle. It switches from the wide to the narrow configuration while code 14 is selected. A design that kept that code would drive a pair index past the end of the multiplexer. It also checks that the wide bit masks the reference choice, and that power-down both raises the ready flag and freezes the result register, so a design that still accepted conversions while powered down would show a changed read-back.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

   localparam int CFG_W  = 8;
   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
   localparam logic [ADDR_W-1:0] A_CHAN = 2'd1;
   localparam logic [ADDR_W-1:0] A_RES  = 2'd2;

   // mode register layout, MSB first: keep-alive, ref2, wide, op[2:0]
   typedef struct packed {
      logic       keep;
      logic       ref2;
      logic       wide;
      logic [2:0] op;
   } mode_t;

   localparam int MODE_W = $bits(mode_t);

   // number of legal codes: single inputs plus pairs
   function automatic int code_limit(input logic wide, input int n_narrow,
                                     input int n_wide);
      return wide ? (n_wide + n_wide / 2) : (n_narrow + n_narrow / 2);
   endfunction

endpackage

// File: rtl/adcc_regs.sv
module adcc_regs
   import adcc_pkg::*;
#(
   parameter int NARROW_CH = 8,
   parameter int WIDE_CH   = 10,
   parameter int SEL_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CFG_W-1:0]  wdata,
   output mode_t             mode_q,
   output logic [SEL_W-1:0]  code_q,
   output logic              chan_err,
   output logic              chg,
   output logic              pd_wr
);

   logic             wr_mode, wr_chan, chan_ok, shrink_bad;
   mode_t            mode_d;
   logic [SEL_W-1:0] code_d;
   int               lim_cur, lim_new;

   always_comb begin
      wr_mode    = wr_en && (addr == A_MODE);
      wr_chan    = wr_en && (addr == A_CHAN);
      mode_d     = mode_t'(wdata[MODE_W-1:0]);
      code_d     = wdata[SEL_W-1:0];
      lim_cur    = code_limit(mode_q.wide, NARROW_CH, WIDE_CH);
      lim_new    = code_limit(mode_d.wide, NARROW_CH, WIDE_CH);
      chan_ok    = int'(code_d) < lim_cur;
      shrink_bad = int'(code_q) >= lim_new;
      chg        = (wr_chan && chan_ok && (code_d != code_q)) ||
                   (wr_mode && (mode_d.wide != mode_q.wide));
      pd_wr      = wr_mode && (mode_d.op == 3'b000);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         code_q   <= '0;
         chan_err <= 1'b0;
      end else if (wr_mode) begin
         mode_q <= mode_d;
         if (shrink_bad) begin
            code_q   <= '0;
            chan_err <= 1'b1;
         end
      end else if (wr_chan) begin
         if (chan_ok) begin
            code_q   <= code_d;
            chan_err <= 1'b0;
         end else begin
            chan_err <= 1'b1;
         end
      end
   end

   a_r3_illegal_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_chan && !chan_ok) |=> (chan_err && $stable(code_q)));

   a_r10_shrink_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && shrink_bad) |=> (code_q == '0 && chan_err));

endmodule

// File: rtl/adcc_settle.sv
module adcc_settle #(
   parameter int SETTLE_CONV = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chg,
   input  logic conv_done,
   input  logic pd,
   output logic busy
);

   generate
      if (SETTLE_CONV == 0) begin : g_none
         assign busy = 1'b0;
      end else begin : g_count
         localparam int CW = $clog2(SETTLE_CONV + 1);
         localparam logic [CW-1:0] LOAD = CW'(SETTLE_CONV);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         cnt <= LOAD;
            else if (chg)                       cnt <= LOAD;
            else if (conv_done && !pd && cnt != '0) cnt <= cnt - 1'b1;
         end

         assign busy = (cnt != '0);

         a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
            chg |=> busy);
      end
   endgenerate

endmodule

// File: rtl/adcc_ready.sv
module adcc_ready #(
   parameter int RES_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [RES_W-1:0] conv_data,
   input  logic             force_hi,
   input  logic             rd_res,
   output logic             rdy_n,
   output logic [RES_W-1:0] res_q
);

   logic blip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_n <= 1'b1;
         blip  <= 1'b0;
      end else if (force_hi) begin
         rdy_n <= 1'b1;
         blip  <= 1'b0;
      end else if (accept) begin
         blip  <= !rdy_n;
         rdy_n <= !rdy_n;
      end else if (rd_res) begin
         rdy_n <= 1'b1;
         blip  <= 1'b0;
      end else if (blip) begin
         rdy_n <= 1'b0;
         blip  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_q <= '0;
      else if (accept) res_q <= conv_data;
   end

   a_r8_first_result_low: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && rdy_n && !force_hi) |=> !rdy_n);

   a_r9_overwrite_blinks: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !rdy_n && !force_hi) |=> rdy_n);

endmodule

// File: rtl/adc_chan_ctrl.sv
module adc_chan_ctrl
   import adcc_pkg::*;
#(
   parameter int NARROW_CH   = 8,
   parameter int WIDE_CH     = 10,
   parameter int SEL_W       = 4,
   parameter int RES_W       = 16,
   parameter int SETTLE_CONV = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [7:0]        wdata,
   output logic [RES_W-1:0]  rdata,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_data,
   output logic [SEL_W-1:0]  mux_pos,
   output logic              mux_diff,
   output logic              ref2_sel,
   output logic              pwr_dn,
   output logic              osc_en,
   output logic              rdy_n,
   output logic              chan_err
);

   localparam logic [SEL_W-1:0] N_NARROW = SEL_W'(NARROW_CH);
   localparam logic [SEL_W-1:0] N_WIDE   = SEL_W'(WIDE_CH);

   generate
      if (WIDE_CH <= NARROW_CH) begin : g_bad_cfg
         $error("wide configuration must have more inputs than narrow");
      end
      if ((WIDE_CH + WIDE_CH / 2) > (1 << SEL_W)) begin : g_bad_sel
         $error("SEL_W too small for channel codes");
      end
      if (SEL_W > CFG_W || RES_W < CFG_W) begin : g_bad_w
         $error("width parameters out of range");
      end
   endgenerate

   mode_t            mode_q;
   logic [SEL_W-1:0] code_q;
   logic             chg, pd_wr, busy, accept, rd_res;
   logic [RES_W-1:0] res_q;
   logic [SEL_W-1:0] n_single;

   adcc_regs #(.NARROW_CH(NARROW_CH), .WIDE_CH(WIDE_CH), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .mode_q(mode_q), .code_q(code_q), .chan_err(chan_err),
      .chg(chg), .pd_wr(pd_wr));

   adcc_settle #(.SETTLE_CONV(SETTLE_CONV)) u_settle (
      .clk(clk), .rst_n(rst_n), .chg(chg), .conv_done(conv_done),
      .pd(pwr_dn), .busy(busy));

   adcc_ready #(.RES_W(RES_W)) u_ready (
      .clk(clk), .rst_n(rst_n), .accept(accept), .conv_data(conv_data),
      .force_hi(pd_wr | chg), .rd_res(rd_res), .rdy_n(rdy_n), .res_q(res_q));

   always_comb begin
      pwr_dn   = (mode_q.op == 3'b000);
      osc_en   = !pwr_dn || mode_q.keep;
      ref2_sel = mode_q.ref2 && !mode_q.wide;
      accept   = conv_done && !pwr_dn && !busy && !chg && !pd_wr;
      rd_res   = rd_en && (addr == A_RES);
      n_single = mode_q.wide ? N_WIDE : N_NARROW;
      if (code_q < n_single) begin
         mux_pos  = code_q;
         mux_diff = 1'b0;
      end else begin
         mux_pos  = code_q - n_single;
         mux_diff = 1'b1;
      end
      rdata = '0;
      if (rd_en) begin
         case (addr)
            A_MODE:  rdata = RES_W'(mode_q);
            A_CHAN:  rdata = RES_W'(code_q);
            A_RES:   rdata = res_q;
            default: rdata = '0;
         endcase
      end
   end

   a_r6_pd_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |-> rdy_n);

   a_r5_osc_only_off_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |-> pwr_dn);

   a_r2_pair_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      mux_diff |-> (mux_pos < (n_single >> 1)));

   a_r12_change_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> rdy_n);

endmodule

// File: tb/tb_adc_chan_ctrl.sv
module tb_adc_chan_ctrl;

   localparam int SETTLE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, conv_done = 1'b0;
   logic [1:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [15:0] conv_data = '0;
   logic [15:0] rdata;
   logic [3:0]  mux_pos;
   logic        mux_diff, ref2_sel, pwr_dn, osc_en, rdy_n, chan_err;

   adc_chan_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .conv_done(conv_done), .conv_data(conv_data),
      .mux_pos(mux_pos), .mux_diff(mux_diff), .ref2_sel(ref2_sel),
      .pwr_dn(pwr_dn), .osc_en(osc_en), .rdy_n(rdy_n), .chan_err(chan_err));

   always #2 clk = ~clk;

   int    n_vec = 0, n_bad = 0, cycles = 0;
   string phase = "R1";

   // behavioural reference model
   int m_op, m_code, m_settle, m_data;
   bit m_wide, m_ref, m_keep, m_err, m_rdy, m_blip;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_op = 0; m_code = 0; m_settle = SETTLE; m_data = 0;
         m_wide = 0; m_ref = 0; m_keep = 0; m_err = 0; m_rdy = 1; m_blip = 0;
      end else begin
         bit wm, wc, rr, pd, chg, pdw, acc, nw;
         int lim_cur, lim_new, nc;
         wm = wr_en && addr == 0;
         wc = wr_en && addr == 1;
         rr = rd_en && addr == 2;
         pd = (m_op == 0);
         nw = wdata[3];
         nc = wdata[3:0];
         lim_cur = m_wide ? 15 : 12;
         lim_new = nw ? 15 : 12;
         chg = (wc && nc < lim_cur && nc != m_code) || (wm && nw != m_wide);
         pdw = wm && wdata[2:0] == 0;
         acc = conv_done && !pd && m_settle == 0 && !chg && !pdw;
         if (chg) m_settle = SETTLE;
         else if (conv_done && !pd && m_settle > 0) m_settle--;
         if (pdw || chg) begin m_rdy = 1; m_blip = 0; end
         else if (acc) begin
            if (!m_rdy) begin m_rdy = 1; m_blip = 1; end
            else begin m_rdy = 0; m_blip = 0; end
         end
         else if (rr) begin m_rdy = 1; m_blip = 0; end
         else if (m_blip) begin m_rdy = 0; m_blip = 0; end
         if (acc) m_data = conv_data;
         if (wm) begin
            m_op = wdata[2:0]; m_wide = nw; m_ref = wdata[4]; m_keep = wdata[5];
            if (m_code >= lim_new) begin m_code = 0; m_err = 1; end
         end else if (wc) begin
            if (nc < lim_cur) begin m_code = nc; m_err = 0; end
            else m_err = 1;
         end
      end
   end

   task automatic cmp(string req, string nm, int got, int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s [%s] %s: actual %0h expected %0h", req, phase, nm, got, exp);
      end
   endtask

   task automatic check_all();
      int nsingle, ep, ed, er;
      nsingle = m_wide ? 10 : 8;
      ed = (m_code >= nsingle);
      ep = ed ? m_code - nsingle : m_code;
      er = 0;
      if (rd_en) case (addr)
         2'd0: er = {m_keep, m_ref, m_wide, 3'(m_op)};
         2'd1: er = m_code;
         2'd2: er = m_data;
         default: er = 0;
      endcase
      cmp("R2",  "mux_pos",  mux_pos,  ep);
      cmp("R2",  "mux_diff", mux_diff, ed);
      cmp("R3",  "chan_err", chan_err, m_err);
      cmp("R4",  "ref2_sel", ref2_sel, m_ref && !m_wide);
      cmp("R5",  "pwr_dn",   pwr_dn,   m_op == 0);
      cmp("R5",  "osc_en",   osc_en,   m_op != 0 || m_keep);
      cmp("R8",  "rdy_n",    rdy_n,    m_rdy);
      cmp("R6",  "rdata",    rdata,    er);
   endtask

   task automatic step(bit w, bit r, logic [1:0] a, logic [7:0] d,
                       bit cd, logic [15:0] cdat);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = a; wdata = d; conv_done = cd; conv_data = cdat;
      #1 check_all();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
   endtask

   task automatic conv(logic [15:0] v); step(0, 0, 0, 0, 1, v); endtask
   task automatic wr(logic [1:0] a, logic [7:0] d); step(1, 0, a, d, 0, 0); endtask
   task automatic rd(logic [1:0] a); step(0, 1, a, 0, 0, 0); endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // R11 / R1: writes during reset ignored, defaults visible
      phase = "R11";
      step(1, 0, 0, 8'h3F, 0, 0);
      step(1, 0, 1, 8'h05, 0, 0);
      step(0, 1, 0, 0, 0, 0);
      @(negedge clk); rst_n = 1'b1;
      phase = "R1";
      rd(0); rd(1); rd(2);

      // R7: three discarded conversions, fourth accepted (R8)
      phase = "R7";
      wr(0, 8'h01);
      conv(16'h1111); conv(16'h2222); conv(16'h3333);
      idle(1);
      phase = "R8";
      conv(16'hA5A5); idle(1); rd(2); idle(1);
      // R9: overwrite of unread result blinks ready
      phase = "R9";
      conv(16'h0101); idle(1); conv(16'h0202); idle(2);
      conv(16'h0303); conv(16'h0404); idle(2); rd(2);

      // R2 / R3 / R12: channel selection, illegal codes
      phase = "R2";
      wr(1, 8'h05); rd(1); wr(1, 8'h09); idle(1);
      wr(1, 8'hFB); idle(1);
      phase = "R3";
      wr(1, 8'h0D); rd(1); wr(1, 8'h0F); wr(1, 8'h0B); idle(1);
      phase = "R12";
      conv(1); conv(2); conv(3); conv(16'hBEEF); idle(1);
      wr(1, 8'h03); idle(1);

      // R4: reference override by wide bit
      phase = "R4";
      wr(0, 8'h11); rd(0); wr(0, 8'h19); rd(0);
      // wide mode: codes up to 14
      phase = "R2";
      wr(1, 8'h0C); wr(1, 8'h0E); wr(1, 8'h0F); rd(1);
      // R10: shrinking the configuration with code 14 selected
      phase = "R10";
      wr(0, 8'h01); rd(1); idle(1);
      wr(1, 8'h0A); idle(1);

      // R6 / R5: power-down while a result is pending
      phase = "R6";
      conv(5); conv(6); conv(7); conv(16'h7E57); idle(1);
      wr(0, 8'h00); conv(16'hDEAD); conv(16'hDEAD); rd(2); rd(0); rd(1);
      phase = "R5";
      wr(0, 8'h20); idle(1); wr(1, 8'h04); rd(1); wr(0, 8'h00); idle(1);
      wr(0, 8'h02); conv(1); conv(2); conv(3); conv(16'h4321); idle(1);

      // R11: mid-run reset restarts everything
      phase = "R11";
      @(negedge clk); rst_n = 1'b0;
      #1 check_all();
      step(1, 0, 0, 8'h07, 1, 16'hFFFF);
      @(negedge clk); rst_n = 1'b1;
      #1 check_all();
      rd(2); wr(0, 8'h03); conv(9); conv(9); conv(9); conv(16'h0042); idle(1); rd(2);
      idle(2);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule